// File: doc/BRIEF.md
# Timed Token-Flow Pipeline Controller

This block is a clocked, cycle-counted model of a linear self-timed pipeline. It is built as a timed token net. Each pipeline stage is a firing point. Each link between two neighbouring stages is a place that holds at most one token, together with a programmable hold time counted in clock cycles.

- The first stage is the source. It injects tokens while `start_i` is high.
- The last stage is the sink. It drains tokens.
- Every interior stage passes a token forward only when three things are true: its input place holds a token, that token has waited out the place's delay, and its output place is empty.

A token sitting in a place stands for a raised request on that channel. Taking the token out stands for the acknowledge that returns the channel to idle. In this way the four-phase return-to-zero exchange is reduced to whole cycles.

Every firing is reported as a one-cycle strobe, one bit per stage, beside the free-running time counter. A downstream block can hang a current pulse on each capture instant. The strobes have no back-pressure: there is no ready input, and the consumer must take every strobe in the cycle it appears. Place delays are written through a small configuration port. They are accepted only while the pipeline is empty, and are kept inside a lower and an upper bound that are supplied as inputs.

Top module: `tflow_pipe`

## Requirements
- R1: Stage s (1 ≤ s ≤ NPLACE) fires only in a cycle where place s-1 holds a token (`occ_o[s-1]` = 1).
- R2: A token deposited into place p by a firing in cycle t lets stage p+1 fire no earlier than cycle t+D+1, where D is the place's delay. If the output of stage p+1 is free, it fires exactly in cycle t+D+1.
- R3: A stage that has an output place (stages 0 to NPLACE-1) fires only in a cycle where that output place is empty.
- R4: When stage s fires, place s-1 reads empty and place s reads full in the following cycle.
- R5: The source (stage 0) fires in every cycle in which `start_i` is high and place 0 is empty, and never while `start_i` is low.
- R6: The sink (stage NPLACE) fires as soon as its input place's delay has elapsed, with no further condition.
- R7: A configuration write (`cfg_we_i` high) takes effect only if all places are empty in that cycle. Otherwise it is dropped.
- R8: A written delay below `dly_min_i` is stored as `dly_min_i`, and one above `dly_max_i` is stored as `dly_max_i`.
- R9: `time_o` holds 0 until the first cycle in which `start_i` is high. From that cycle on it increases by one every cycle, so that its value in a cycle equals the number of cycles since that first start cycle.
- R10: Each firing of stage s raises bit s of `fire_o` for exactly one cycle. The time stamp of that firing is the value of `time_o` in that same cycle.
- R11: After reset, every place is empty, `fire_o` and `time_o` are 0, and every place delay equals DLY_RST (2 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Source enable. While it is high, the source injects a token whenever place 0 is empty. |
| cfg_we_i | input | 1 | Delay write strobe |
| cfg_idx_i | input | IDX_W | Place selected for the write |
| cfg_dly_i | input | DLY_W | Delay value to write, in cycles |
| dly_min_i | input | DLY_W | Lower bound applied to written delays |
| dly_max_i | input | DLY_W | Upper bound applied to written delays |
| fire_o | output | NPLACE+1 | One-cycle fire strobe per stage. Bit 0 is the source and the top bit is the sink. |
| occ_o | output | NPLACE | Token present in each place |
| time_o | output | 32 | Time stamp counter |

## Verification
The main function is exercised with four patterns.
- A single start pulse through unequal delays, including a zero delay. This separates the per-place wait from the hand-on cycle and checks that each stage emits exactly one strobe.
- A start level held high behind one long place. Tokens pile up against the occupied place, which shows that a full output place blocks firing and that the source refills in exactly the cycle its place drains.
- Writes below the minimum and above the maximum. These show up as changed firing instants.
- A write made while a token is in flight, compared with the same write made while the pipeline is empty. This separates the idle-only update rule from an unconditional write.

// File: rtl/tflow_pkg.sv
package tflow_pkg;

  localparam int TIME_W = 32;

  typedef enum logic [1:0] {
    ROLE_SRC,
    ROLE_MID,
    ROLE_SNK
  } role_e;

  function automatic role_e role_of(input int s, input int nstg);
    if (s == 0)        return ROLE_SRC;
    if (s == nstg - 1) return ROLE_SNK;
    return ROLE_MID;
  endfunction

endpackage

// File: rtl/tflow_place.sv
module tflow_place #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put_i,
  input  logic             take_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             tok_o,
  output logic             ripe_o
);

  logic             tok_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_q <= 1'b0;
      cnt_q <= '0;
    end else if (put_i) begin
      tok_q <= 1'b1;
      cnt_q <= dly_i;
    end else if (take_i) begin
      tok_q <= 1'b0;
    end else if (tok_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tok_o  = tok_q;
  assign ripe_o = tok_q && (cnt_q == '0);

endmodule

// File: rtl/tflow_dly_bank.sv
module tflow_dly_bank #(
  parameter int NPLACE  = 4,
  parameter int DLY_W   = 4,
  parameter int DLY_RST = 2,
  localparam int IDX_W  = (NPLACE > 1) ? $clog2(NPLACE) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [DLY_W-1:0]               val_i,
  input  logic [DLY_W-1:0]               lo_i,
  input  logic [DLY_W-1:0]               hi_i,
  input  logic                           idle_i,
  output logic [NPLACE-1:0][DLY_W-1:0]   dly_o
);

  logic [DLY_W-1:0] bounded;

  always_comb begin
    if (val_i < lo_i)      bounded = lo_i;
    else if (val_i > hi_i) bounded = hi_i;
    else                   bounded = val_i;
  end

  for (genvar p = 0; p < NPLACE; p++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        dly_o[p] <= DLY_W'(DLY_RST);
      else if (we_i && idle_i && (idx_i == IDX_W'(p)))
        dly_o[p] <= bounded;
    end
  end

endmodule

// File: rtl/tflow_clock.sv
module tflow_clock (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  output logic [tflow_pkg::TIME_W-1:0]  time_o
);

  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      time_o <= '0;
    end else begin
      if (start_i) run_q <= 1'b1;
      if (run_q || start_i) time_o <= time_o + 1'b1;
    end
  end

endmodule

// File: rtl/tflow_pipe.sv
module tflow_pipe #(
  parameter int NPLACE  = 4,
  parameter int DLY_W   = 4,
  parameter int DLY_RST = 2,
  localparam int NSTG   = NPLACE + 1,
  localparam int IDX_W  = (NPLACE > 1) ? $clog2(NPLACE) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          cfg_we_i,
  input  logic [IDX_W-1:0]              cfg_idx_i,
  input  logic [DLY_W-1:0]              cfg_dly_i,
  input  logic [DLY_W-1:0]              dly_min_i,
  input  logic [DLY_W-1:0]              dly_max_i,
  output logic [NSTG-1:0]               fire_o,
  output logic [NPLACE-1:0]             occ_o,
  output logic [tflow_pkg::TIME_W-1:0]  time_o
);

  import tflow_pkg::*;

  logic [NSTG-1:0]                fire;
  logic [NPLACE-1:0]              tok;
  logic [NPLACE-1:0]              ripe;
  logic [NPLACE-1:0][DLY_W-1:0]   dly;
  logic                           idle;

  assign idle = ~|tok;

  tflow_dly_bank #(
    .NPLACE (NPLACE),
    .DLY_W  (DLY_W),
    .DLY_RST(DLY_RST)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (cfg_we_i),
    .idx_i (cfg_idx_i),
    .val_i (cfg_dly_i),
    .lo_i  (dly_min_i),
    .hi_i  (dly_max_i),
    .idle_i(idle),
    .dly_o (dly)
  );

  tflow_clock u_clock (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .time_o (time_o)
  );

  // Stage firing rules: token present and ripe on the input side,
  // free place on the output side; source gated by start, sink unconditional.
  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    localparam role_e ROLE = role_of(s, NSTG);
    if (ROLE == ROLE_SRC) begin : g_src
      assign fire[s] = start_i && !tok[0];
    end else if (ROLE == ROLE_SNK) begin : g_snk
      assign fire[s] = ripe[s-1];
    end else begin : g_mid
      assign fire[s] = ripe[s-1] && !tok[s];
    end
  end

  for (genvar p = 0; p < NPLACE; p++) begin : g_place
    tflow_place #(.DLY_W(DLY_W)) u_place (
      .clk   (clk),
      .rst_n (rst_n),
      .put_i (fire[p]),
      .take_i(fire[p+1]),
      .dly_i (dly[p]),
      .tok_o (tok[p]),
      .ripe_o(ripe[p])
    );
  end

  assign fire_o = fire;
  assign occ_o  = tok;

endmodule

// File: rtl/tflow_pipe_chk.sv
module tflow_pipe_chk #(
  parameter int NPLACE = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start_i,
  input logic [NPLACE:0]               fire_o,
  input logic [NPLACE-1:0]             occ_o,
  input logic [tflow_pkg::TIME_W-1:0]  time_o
);

  a_r5_src_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o[0] |-> start_i);

  a_r9_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_i) || ($past(time_o) != '0)) |-> (time_o == $past(time_o) + 1'b1));

  for (genvar p = 0; p < NPLACE; p++) begin : g_pl
    a_r1_token_present: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o[p+1] |-> occ_o[p]);
    a_r3_out_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o[p] |-> !occ_o[p]);
    a_r4_deposit: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o[p] |=> occ_o[p]);
    a_r4_remove: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o[p+1] |=> !occ_o[p]);
  end

endmodule

bind tflow_pipe tflow_pipe_chk #(.NPLACE(NPLACE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .fire_o (fire_o),
  .occ_o  (occ_o),
  .time_o (time_o)
);

// File: tb/sim_tflow_pipe.sv
module sim_tflow_pipe;

  localparam int NPLACE = 4;
  localparam int DLY_W  = 4;
  localparam int NSTG   = NPLACE + 1;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic              cfg_we_i;
  logic [IDX_W-1:0]  cfg_idx_i;
  logic [DLY_W-1:0]  cfg_dly_i, dly_min_i, dly_max_i;
  logic [NSTG-1:0]   fire_o;
  logic [NPLACE-1:0] occ_o;
  logic [31:0]       time_o;

  int nchk = 0;
  int nfail = 0;
  int fc [NSTG];
  int ft [NSTG][4];
  logic [NPLACE-1:0] occ_h [64];
  logic [31:0]       time_h [64];

  always #4 clk = ~clk;

  tflow_pipe #(.NPLACE(NPLACE), .DLY_W(DLY_W), .DLY_RST(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_we_i(cfg_we_i),
    .cfg_idx_i(cfg_idx_i), .cfg_dly_i(cfg_dly_i), .dly_min_i(dly_min_i),
    .dly_max_i(dly_max_i), .fire_o(fire_o), .occ_o(occ_o), .time_o(time_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0; cfg_we_i = 1'b0; cfg_idx_i = '0;
    cfg_dly_i = '0; dly_min_i = 4'd0; dly_max_i = 4'd15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_idx_i = IDX_W'(idx); cfg_dly_i = DLY_W'(val);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // Step k is sampled 1 ns after the k-th falling edge from the start edge.
  task automatic run(input bit hold, input int ncyc, input int wr_k,
                     input int wr_idx, input int wr_val);
    for (int s = 0; s < NSTG; s++) begin
      fc[s] = 0;
      for (int i = 0; i < 4; i++) ft[s][i] = -1;
    end
    @(negedge clk);
    start_i = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      if (k > 0) begin
        @(negedge clk);
        if (!hold) start_i = 1'b0;
      end
      cfg_we_i = (k == wr_k);
      if (k == wr_k) begin
        cfg_idx_i = IDX_W'(wr_idx);
        cfg_dly_i = DLY_W'(wr_val);
      end
      #1;
      for (int s = 0; s < NSTG; s++) begin
        if (fire_o[s]) begin
          if (fc[s] < 4) ft[s][fc[s]] = int'(time_o);
          fc[s]++;
        end
      end
      occ_h[k]  = occ_o;
      time_h[k] = time_o;
    end
    @(negedge clk);
    start_i = 1'b0; cfg_we_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R11 occupancy after reset", 32'(occ_o), 0);
    chk("R11 fire after reset", 32'(fire_o), 0);
    chk("R9 time idle before start", time_o, 0);
    run(1'b0, 16, -1, 0, 0);
    chk("R11 default delay sink stamp", ft[NSTG-1][0], 12);
  endtask

  task automatic t_single();
    do_reset();
    wr(0, 1); wr(1, 3); wr(2, 0); wr(3, 5);
    run(1'b0, 20, -1, 0, 0);
    chk("R5 source stamp", ft[0][0], 0);
    chk("R2 stage1 stamp", ft[1][0], 2);
    chk("R2 stage2 stamp", ft[2][0], 6);
    chk("R2 zero-delay stage3 stamp", ft[3][0], 7);
    chk("R6 sink stamp", ft[4][0], 13);
    for (int s = 0; s < NSTG; s++) chk("R10 one strobe per stage", fc[s], 1);
    chk("R4 occupancy step1", 32'(occ_h[1]), 32'h1);
    chk("R4 occupancy step3", 32'(occ_h[3]), 32'h2);
    chk("R4 occupancy step7", 32'(occ_h[7]), 32'h4);
    chk("R4 occupancy drained", 32'(occ_h[19]), 0);
    chk("R9 time step10", time_h[10], 10);
  endtask

  task automatic t_clamp();
    do_reset();
    dly_min_i = 4'd2; dly_max_i = 4'd6;
    wr(0, 0); wr(1, 9); wr(2, 4); wr(3, 1);
    run(1'b0, 22, -1, 0, 0);
    chk("R8 low clamp stage1", ft[1][0], 3);
    chk("R8 high clamp stage2", ft[2][0], 10);
    chk("R8 in-range stage3", ft[3][0], 15);
    chk("R8 low clamp sink", ft[4][0], 18);
  endtask

  task automatic t_busy_write();
    do_reset();
    wr(0, 3); wr(1, 3); wr(2, 3); wr(3, 3);
    run(1'b0, 20, 2, 3, 0);
    chk("R7 busy write dropped sink", ft[4][0], 16);
    wr(3, 0);
    run(1'b0, 16, -1, 0, 0);
    chk("R7 idle write taken span", 32'(ft[4][0] - ft[0][0]), 13);
  endtask

  task automatic t_backpressure();
    do_reset();
    wr(0, 0); wr(1, 8); wr(2, 0); wr(3, 0);
    run(1'b1, 16, -1, 0, 0);
    chk("R5 source refill stamp", ft[0][1], 2);
    chk("R3 stage1 blocked stamp", ft[1][1], 11);
    chk("R5 source third stamp", ft[0][2], 12);
    chk("R5 source count", fc[0], 3);
    chk("R3 occupancy pile-up", 32'(occ_h[5]), 32'h3);
    chk("R6 sink stamp", ft[4][0], 12);
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_clamp();
    t_busy_write();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule